// File: doc/BRIEF.md
# Character LCD Nibble-Mode Writer

This block sits between a host that produces text bytes and a character display module wired with a 4-bit data path. The host sees a very small interface. It places a byte on an 8-bit input and pulses a one-cycle strobe while the busy output is low. The block captures the byte on that cycle, splits it into two 4-bit transfers and drives the display's enable strobe, register-select and read/write lines. It keeps busy asserted until the display has had enough time to absorb the character.

After reset the block brings the display up by itself, so no software driver is needed. It waits for the display's power-on time. It then issues the wake-up nibble sequence that forces the display into 4-bit mode, followed by a fixed set of configuration commands: two-line 4-bit function set, incrementing entry mode, display on with the cursor hidden, and clear. Busy stays high for the whole of this start-up. Every delay is a cycle count derived from a clock-frequency parameter, so a testbench can use a low nominal frequency to keep runs short.

Top module: `lcd_nibble_writer`

## Requirements
- R1: A synchronous active-high reset leaves busy high and enable low on the first cycle after it is released. It restarts the whole start-up sequence, whose first enable pulse comes no earlier than 15 ms of clock cycles after reset.
- R2: The start-up sends the nibbles 0x3, 0x3, 0x3, 0x2 with register-select low. Between the enable pulses of consecutive nibbles it leaves gaps of at least 4.1 ms, 100 us and 40 us, in that order.
- R3: After the wake-up nibbles, the start-up sends the command bytes 0x28, 0x06, 0x0C and 0x01 in that order, each as two nibbles with register-select low. Busy falls no earlier than 1.64 ms after the last enable pulse of the clear command (0x01).
- R4: Busy stays high from reset until the start-up has finished. Enable never goes high while busy is low.
- R5: A one-cycle strobe while busy is low captures the byte. Busy is high on the next cycle, and the data input may change after the strobe cycle without affecting the transfer.
- R6: A host byte goes out as two enable pulses with register-select high. The data lines carry bits 7:4 on the first pulse and bits 3:0 on the second.
- R7: After the second nibble of any byte, busy stays high for at least 40 us of clock cycles past the falling edge of enable. The only exception is the start-up clear command, which uses the longer wait of R3.
- R8: A strobe that arrives while busy is high is ignored: it produces no enable pulse, either during the current transfer or after it.
- R9: The data nibble and register-select are stable for at least one cycle before enable rises and for the whole time enable is high. Enable stays high for at least EN_HIGH_CYC cycles (12 by default).
- R10: The read/write line is low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Character byte from the host |
| wr_stb | input | 1 | One-cycle strobe, accepted only while busy is low |
| busy | output | 1 | High during start-up and during each byte transfer |
| lcd_data | output | 4 | Nibble driven to the display data lines |
| lcd_en | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Register select: high for character data, low for commands |
| lcd_rw | output | 1 | Read/write select, tied low |

## Verification
The bound checker watches the display-side timing on every cycle. It checks that the nibble and register-select do not move while enable is high or on the cycle it rises, that each enable pulse is long enough, that enable never rises while busy is low, that read/write stays low, and that busy rises right after an accepted strobe and holds its reset value. Other properties span thousands of cycles or need the whole nibble stream: the exact start-up order, the gaps after each wake-up nibble, the long wait after clear, upper-nibble-first order for host bytes, and the silent discard of strobes during busy. The bench's directed scenarios check these by recording every enable pulse and the cycle on which it occurs.

// File: rtl/lcd_nib_pkg.sv
package lcd_nib_pkg;

    // controller states
    typedef enum logic [3:0] {
        C_BOOT,      // load the power-on delay
        C_PWR,       // wait for display power-on
        C_NIB,       // wake-up nibble on the bus
        C_NIB_WAIT,  // gap after a wake-up nibble
        C_HI,        // upper nibble of a byte on the bus
        C_MID,       // short gap between nibbles
        C_LO,        // lower nibble of a byte on the bus
        C_POST,      // settling delay after a full byte
        C_IDLE       // ready for host data
    } ctrl_state_e;

    // nibble strobe engine states
    typedef enum logic [1:0] {
        P_IDLE,
        P_SETUP,
        P_HIGH,
        P_HOLD
    } phy_state_e;

    localparam logic [7:0] CMD_CLEAR = 8'h01;

    // configuration commands issued after the wake-up nibbles
    function automatic logic [7:0] init_cmd(input logic [1:0] idx);
        logic [7:0] c;
        case (idx)
            2'd0:    c = 8'h28;   // 4-bit bus, two lines, 5x8 font
            2'd1:    c = 8'h06;   // increment address, no shift
            2'd2:    c = 8'h0C;   // display on, cursor off
            default: c = CMD_CLEAR;
        endcase
        return c;
    endfunction

    // wake-up nibbles: three times 0x3, then 0x2 to enter 4-bit mode
    function automatic logic [3:0] wake_nibble(input logic [1:0] idx);
        return (idx == 2'd3) ? 4'h2 : 4'h3;
    endfunction

    // a delay count of zero would skip the wait, so keep at least one
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = value;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd_nib_phy.sv
module lcd_nib_phy
    import lcd_nib_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned EN_HIGH_CYC = 12,
    parameter int unsigned HOLD_CYC    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [3:0] nib_in,
    input  logic       rs_in,
    output logic       ready,
    output logic [3:0] nib_out,
    output logic       en_out,
    output logic       rs_out
);

    localparam int unsigned SETUP_N = at_least_one(SETUP_CYC);
    localparam int unsigned HIGH_N  = at_least_one(EN_HIGH_CYC);
    localparam int unsigned HOLD_N  = at_least_one(HOLD_CYC);
    localparam int unsigned MAX_A   = (SETUP_N > HIGH_N) ? SETUP_N : HIGH_N;
    localparam int unsigned MAX_N   = (MAX_A > HOLD_N) ? MAX_A : HOLD_N;
    localparam int unsigned CW      = $clog2(MAX_N + 1);

    typedef struct packed {
        phy_state_e    st;
        logic [CW-1:0] cnt;
        logic [3:0]    nib;
        logic          rs;
        logic          en;
    } phy_t;

    phy_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            P_IDLE: begin
                if (start) begin
                    d.nib = nib_in;
                    d.rs  = rs_in;
                    d.cnt = CW'(SETUP_N - 1);
                    d.st  = P_SETUP;
                end
            end
            P_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = P_HIGH;
                    d.en  = 1'b1;
                    d.cnt = CW'(HIGH_N - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            P_HIGH: begin
                if (q.cnt == '0) begin
                    d.st  = P_HOLD;
                    d.en  = 1'b0;
                    d.cnt = CW'(HOLD_N - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                if (q.cnt == '0) begin
                    d.st = P_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: P_IDLE, cnt: '0, nib: 4'h0, rs: 1'b0, en: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ready   = (q.st == P_IDLE);
    assign nib_out = q.nib;
    assign en_out  = q.en;
    assign rs_out  = q.rs;

endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer
    import lcd_nib_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned EN_HIGH_CYC = 12,
    parameter int unsigned SETUP_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] wr_data,
    input  logic       wr_stb,
    output logic       busy,
    output logic [3:0] lcd_data,
    output logic       lcd_en,
    output logic       lcd_rs,
    output logic       lcd_rw
);

    // delay limits in clock cycles
    localparam int unsigned T_PWR   = at_least_one((CLK_HZ / 1000) * 15);     // 15 ms
    localparam int unsigned T_WAKE1 = at_least_one((CLK_HZ / 10000) * 41);    // 4.1 ms
    localparam int unsigned T_WAKE2 = at_least_one(CLK_HZ / 10000);           // 100 us
    localparam int unsigned T_CMD   = at_least_one(CLK_HZ / 25000);           // 40 us
    localparam int unsigned T_CLEAR = at_least_one((CLK_HZ / 100000) * 164);  // 1.64 ms
    localparam int unsigned T_GAP   = at_least_one(CLK_HZ / 1000000);         // 1 us
    localparam int unsigned TW      = $clog2(T_PWR + 1);

    localparam logic [TW-1:0] L_PWR   = TW'(T_PWR);
    localparam logic [TW-1:0] L_WAKE1 = TW'(T_WAKE1);
    localparam logic [TW-1:0] L_WAKE2 = TW'(T_WAKE2);
    localparam logic [TW-1:0] L_CMD   = TW'(T_CMD);
    localparam logic [TW-1:0] L_CLEAR = TW'(T_CLEAR);
    localparam logic [TW-1:0] L_GAP   = TW'(T_GAP);

    typedef struct packed {
        ctrl_state_e st;
        logic [1:0]  step;
        logic [7:0]  byte_v;
        logic        rs;
        logic        booted;
        logic        busy;
    } ctrl_t;

    ctrl_t d, q;

    logic          phy_start;
    logic [3:0]    phy_nib;
    logic          phy_rs;
    logic          phy_ready;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;

    lcd_nib_phy #(
        .SETUP_CYC  (SETUP_CYC),
        .EN_HIGH_CYC(EN_HIGH_CYC),
        .HOLD_CYC   (1)
    ) u_phy (
        .clk    (clk),
        .rst    (rst),
        .start  (phy_start),
        .nib_in (phy_nib),
        .rs_in  (phy_rs),
        .ready  (phy_ready),
        .nib_out(lcd_data),
        .en_out (lcd_en),
        .rs_out (lcd_rs)
    );

    lcd_delay_timer #(
        .W(TW)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .value  (tmr_val),
        .expired(tmr_done)
    );

    // gap that follows each wake-up nibble
    function automatic logic [TW-1:0] wake_gap(input logic [1:0] idx);
        logic [TW-1:0] g;
        case (idx)
            2'd0:    g = L_WAKE1;
            2'd1:    g = L_WAKE2;
            default: g = L_CMD;
        endcase
        return g;
    endfunction

    always_comb begin
        d         = q;
        phy_start = 1'b0;
        phy_nib   = 4'h0;
        phy_rs    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;

        case (q.st)
            C_BOOT: begin
                tmr_load = 1'b1;
                tmr_val  = L_PWR;
                d.st     = C_PWR;
            end
            C_PWR: begin
                if (tmr_done) begin
                    d.step    = 2'd0;
                    phy_start = 1'b1;
                    phy_nib   = wake_nibble(2'd0);
                    phy_rs    = 1'b0;
                    d.st      = C_NIB;
                end
            end
            C_NIB: begin
                if (phy_ready) begin
                    tmr_load = 1'b1;
                    tmr_val  = wake_gap(q.step);
                    d.st     = C_NIB_WAIT;
                end
            end
            C_NIB_WAIT: begin
                if (tmr_done) begin
                    if (q.step != 2'd3) begin
                        d.step    = q.step + 2'd1;
                        phy_start = 1'b1;
                        phy_nib   = wake_nibble(q.step + 2'd1);
                        phy_rs    = 1'b0;
                        d.st      = C_NIB;
                    end else begin
                        d.step    = 2'd0;
                        d.byte_v  = init_cmd(2'd0);
                        d.rs      = 1'b0;
                        phy_start = 1'b1;
                        phy_nib   = init_cmd(2'd0) >> 4;
                        phy_rs    = 1'b0;
                        d.st      = C_HI;
                    end
                end
            end
            C_HI: begin
                if (phy_ready) begin
                    tmr_load = 1'b1;
                    tmr_val  = L_GAP;
                    d.st     = C_MID;
                end
            end
            C_MID: begin
                if (tmr_done) begin
                    phy_start = 1'b1;
                    phy_nib   = q.byte_v[3:0];
                    phy_rs    = q.rs;
                    d.st      = C_LO;
                end
            end
            C_LO: begin
                if (phy_ready) begin
                    tmr_load = 1'b1;
                    tmr_val  = (!q.rs && q.byte_v == CMD_CLEAR) ? L_CLEAR : L_CMD;
                    d.st     = C_POST;
                end
            end
            C_POST: begin
                if (tmr_done) begin
                    if (q.booted) begin
                        d.st = C_IDLE;
                    end else if (q.step != 2'd3) begin
                        d.step    = q.step + 2'd1;
                        d.byte_v  = init_cmd(q.step + 2'd1);
                        phy_start = 1'b1;
                        phy_nib   = init_cmd(q.step + 2'd1) >> 4;
                        phy_rs    = 1'b0;
                        d.st      = C_HI;
                    end else begin
                        d.booted = 1'b1;
                        d.st     = C_IDLE;
                    end
                end
            end
            default: begin  // C_IDLE
                if (wr_stb) begin
                    d.byte_v  = wr_data;
                    d.rs      = 1'b1;
                    phy_start = 1'b1;
                    phy_nib   = wr_data[7:4];
                    phy_rs    = 1'b1;
                    d.st      = C_HI;
                end
            end
        endcase

        d.busy = (d.st != C_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: C_BOOT, step: 2'd0, byte_v: 8'h00, rs: 1'b0,
                   booted: 1'b0, busy: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign busy   = q.busy;
    assign lcd_rw = 1'b0;

endmodule

// File: rtl/lcd_nibble_writer_chk.sv
module lcd_nibble_writer_chk #(
    parameter int unsigned EN_HIGH_CYC = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic       busy,
    input logic [3:0] lcd_data,
    input logic       lcd_en,
    input logic       lcd_rs,
    input logic       lcd_rw
);

    logic [15:0] hi_cnt;
    logic        rst_d1;

    always_ff @(posedge clk) begin
        rst_d1 <= rst;
        if (rst || !lcd_en) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 16'd1;
        end
    end

    // R1: outputs right after reset release
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        rst_d1 |-> (busy && !lcd_en));

    // R4: enable only while busy
    assert_en_under_busy_R4: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> busy);

    // R5: accepted strobe raises busy next cycle
    assert_busy_after_stb_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_stb) |=> busy);

    // R9: setup before enable rises
    assert_setup_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    // R9: stable while enable high
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    // R9: minimum enable width
    assert_en_width_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> (hi_cnt >= 16'(EN_HIGH_CYC)));

    // R10: write-only
    assert_rw_low_R10: assert property (@(posedge clk) disable iff (rst)
        !lcd_rw);

endmodule

bind lcd_nibble_writer lcd_nibble_writer_chk #(
    .EN_HIGH_CYC(EN_HIGH_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .busy    (busy),
    .lcd_data(lcd_data),
    .lcd_en  (lcd_en),
    .lcd_rs  (lcd_rs),
    .lcd_rw  (lcd_rw)
);

// File: tb/tb_lcd_nibble_writer.sv
module tb_lcd_nibble_writer;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    // expected delays at 1 MHz, from the requirements
    localparam int T_PWR   = 15000;
    localparam int T_WAKE1 = 4100;
    localparam int T_WAKE2 = 100;
    localparam int T_CMD   = 40;
    localparam int T_CLEAR = 1640;
    localparam int EN_MIN  = 12;
    localparam int SLACK   = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic       wr_stb = 1'b0;
    logic       busy;
    logic [3:0] lcd_data;
    logic       lcd_en;
    logic       lcd_rs;
    logic       lcd_rw;

    lcd_nibble_writer #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_stb(wr_stb),
        .busy(busy), .lcd_data(lcd_data), .lcd_en(lcd_en),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_bad    = 0;

    // monitor state
    int         cyc = 0;
    int         rise_cyc [256];
    logic [3:0] rise_nib [256];
    logic       rise_rs  [256];
    int         n_rise = 0;
    int         fall_cyc = 0;
    int         busy_fall_cyc = 0;
    int         n_bfall = 0;
    int         hi_cnt = 0;
    logic       prev_en = 1'b0;
    logic       prev_busy = 1'b1;
    logic [3:0] prev_nib = 4'h0;
    logic       prev_rs = 1'b0;
    bit rw_bad = 0, setup_bad = 0, hold_bad = 0, width_bad = 0, en_idle_bad = 0;

    int base = 0;
    int rel_cyc = 0;
    int bfall_base = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (lcd_rw !== 1'b0) rw_bad = 1;
        if (lcd_en && !busy) en_idle_bad = 1;
        if (lcd_en && !prev_en) begin
            if (n_rise < 256) begin
                rise_cyc[n_rise] = cyc;
                rise_nib[n_rise] = lcd_data;
                rise_rs[n_rise]  = lcd_rs;
            end
            n_rise = n_rise + 1;
            if (lcd_data !== prev_nib || lcd_rs !== prev_rs) setup_bad = 1;
        end
        if (lcd_en && prev_en && (lcd_data !== prev_nib || lcd_rs !== prev_rs)) hold_bad = 1;
        if (!lcd_en && prev_en) begin
            fall_cyc = cyc;
            if (!rst && hi_cnt < EN_MIN) width_bad = 1;
        end
        hi_cnt = lcd_en ? hi_cnt + 1 : 0;
        if (prev_busy && !busy) begin
            busy_fall_cyc = cyc;
            n_bfall = n_bfall + 1;
        end
        prev_en   = lcd_en;
        prev_busy = busy;
        prev_nib  = lcd_data;
        prev_rs   = lcd_rs;
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle(input int limit, input string req);
        int n = 0;
        while (busy !== 1'b0 && n < limit) begin
            tick();
            n++;
        end
        check(busy === 1'b0, req, "busy never fell", 1, 0);
    endtask

    // R1: reset state
    task automatic t_reset();
        tick();
        rst    = 1'b1;
        wr_stb = 1'b0;
        repeat (3) tick();
        check(busy === 1'b1 && lcd_en === 1'b0, "R1", "busy/en during reset",
              {busy, lcd_en}, 2'b10);
        rst        = 1'b0;
        base       = n_rise;
        rel_cyc    = cyc;
        bfall_base = n_bfall;
        tick();
        check(busy === 1'b1 && lcd_en === 1'b0, "R1", "busy/en after release",
              {busy, lcd_en}, 2'b10);
    endtask

    // R1 R2 R3 R4: start-up sequence
    task automatic t_init();
        logic [3:0] exp_nib [12] = '{4'h3, 4'h3, 4'h3, 4'h2, 4'h2, 4'h8,
                                     4'h0, 4'h6, 4'h0, 4'hC, 4'h0, 4'h1};
        int bad_i = -1;
        int d;
        wait_idle(40000, "R4");
        check(n_rise - base == 12, "R3", "start-up pulse count", n_rise - base, 12);
        for (int i = 0; i < 12; i++) begin
            if (bad_i < 0 && (rise_nib[base + i] !== exp_nib[i] || rise_rs[base + i] !== 1'b0))
                bad_i = i;
        end
        check(bad_i < 0, "R2", "start-up nibble/rs order, first bad index", bad_i, -1);
        d = rise_cyc[base] - rel_cyc;
        check(d >= T_PWR && d <= T_PWR + SLACK, "R1", "power-on delay", d, T_PWR);
        d = rise_cyc[base + 1] - rise_cyc[base];
        check(d >= T_WAKE1 + EN_MIN && d <= T_WAKE1 + SLACK, "R2", "gap 1", d, T_WAKE1);
        d = rise_cyc[base + 2] - rise_cyc[base + 1];
        check(d >= T_WAKE2 + EN_MIN && d <= T_WAKE2 + SLACK, "R2", "gap 2", d, T_WAKE2);
        d = rise_cyc[base + 3] - rise_cyc[base + 2];
        check(d >= T_CMD + EN_MIN && d <= T_CMD + SLACK, "R2", "gap 3", d, T_CMD);
        d = busy_fall_cyc - fall_cyc;
        check(d >= T_CLEAR && d <= T_CLEAR + 10, "R3", "wait after clear", d, T_CLEAR);
        check(n_bfall - bfall_base == 1, "R4", "busy falls once during start-up",
              n_bfall - bfall_base, 1);
    endtask

    // R5 R6 R7: one host byte
    task automatic t_write(input logic [7:0] b);
        int d;
        check(busy === 1'b0, "R4", "idle before write", busy, 0);
        wr_data = b;
        wr_stb  = 1'b1;
        base    = n_rise;
        tick();
        wr_stb  = 1'b0;
        wr_data = ~b;
        check(busy === 1'b1, "R5", "busy after strobe", busy, 1);
        wait_idle(2000, "R7");
        check(n_rise - base == 2, "R6", "pulses per byte", n_rise - base, 2);
        check(rise_nib[base] === b[7:4] && rise_rs[base] === 1'b1, "R6",
              "upper nibble", {rise_rs[base], rise_nib[base]}, {1'b1, b[7:4]});
        check(rise_nib[base + 1] === b[3:0] && rise_rs[base + 1] === 1'b1, "R5",
              "lower nibble after data changed", {rise_rs[base + 1], rise_nib[base + 1]},
              {1'b1, b[3:0]});
        d = busy_fall_cyc - fall_cyc;
        check(d >= T_CMD && d <= T_CMD + 10, "R7", "wait after byte", d, T_CMD);
        tick();
    endtask

    // R8: strobe during busy ignored
    task automatic t_ignore();
        int b0;
        wr_data = 8'h5A;
        wr_stb  = 1'b1;
        base    = n_rise;
        tick();
        wr_stb = 1'b0;
        repeat (3) tick();
        wr_data = 8'hC3;
        wr_stb  = 1'b1;
        tick();
        wr_stb = 1'b0;
        wait_idle(2000, "R8");
        check(n_rise - base == 2, "R8", "pulses with extra strobe", n_rise - base, 2);
        check(rise_nib[base] === 4'h5 && rise_nib[base + 1] === 4'hA, "R8",
              "nibbles with extra strobe", {rise_nib[base], rise_nib[base + 1]}, 8'h5A);
        b0 = n_rise;
        repeat (100) tick();
        check(n_rise == b0 && busy === 1'b0, "R8", "no late transfer",
              n_rise - b0, 0);
    endtask

    // R1: reset in the middle of a byte
    task automatic t_mid_reset();
        wr_data = 8'h77;
        wr_stb  = 1'b1;
        tick();
        wr_stb = 1'b0;
        repeat (8) tick();
        t_reset();
        t_init();
    endtask

    // R4 R9 R10: flags from the monitor
    task automatic t_flags();
        check(!rw_bad, "R10", "read/write went high", rw_bad, 0);
        check(!setup_bad, "R9", "data moved at enable rise", setup_bad, 0);
        check(!hold_bad, "R9", "data moved while enable high", hold_bad, 0);
        check(!width_bad, "R9", "enable pulse too short", width_bad, 0);
        check(!en_idle_bad, "R4", "enable while not busy", en_idle_bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_init();
        t_write(8'h41);
        t_write(8'hFF);
        t_write(8'h00);
        t_write(8'h01);
        t_ignore();
        t_mid_reset();
        t_write(8'hA5);
        t_flags();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule